// File: doc/BRIEF.md
# Multi-Plane Configuration Store

This block keeps several complete planes of configuration bits for a reconfigurable fabric. Each plane is organised as rows of 32-bit column words. Exactly one plane is active at a time. Its contents sit in a dedicated holding register, and that register alone drives the fabric. The fabric therefore sees stable bits while the host rewrites any plane in the background.

A host write names a context, a row and a column. The word is stored only where all three address decoders agree. Each plane is randomly addressable, so a partial update needs only the changed words. A readback port returns any stored word one cycle after the request.

A switch request makes another plane active. The switch runs in two steps. In the detach cycle the holding register is cut off from the storage. In the load cycle it captures the selected plane. The block is busy during both cycles, and the host must hold off writes and further switches until busy falls. The number of planes is a parameter with the value 2, 4 or 8. Rows and columns must each be a power of two, at least 2.

Top module: `cfg_context_mem`

## Requirements
- R1: After synchronous reset, every stored word reads back as zero, `cfg_out` is all zero, `active_ctx` is 0, and `busy` and `rd_valid` are low.
- R2: When `busy` is low, a `wr_req` stores `wr_data` into the word selected by `wr_ctx`, `wr_row` and `wr_col`, and into no other word.
- R3: A write to any context, including the active one, leaves `cfg_out` unchanged. The held copy of the active plane changes only when a plane is loaded.
- R4: `rd_data` returns the stored word for `rd_ctx`, `rd_row` and `rd_col` at the first clock edge after the request, and `rd_valid` is high in exactly that cycle. Reading the active context returns the stored word, not the held one. A read and a write to the same word in the same cycle return the old value.
- R5: A `sw_req` accepted while idle raises `busy` for exactly two cycles, a detach cycle followed by a load cycle. During both cycles `cfg_out` and `active_ctx` hold their old values. At the edge that ends the load cycle, `cfg_out` takes the selected plane and `active_ctx` becomes `sw_ctx`.
- R6: A `wr_req` presented while `busy` is high is dropped and changes no stored word.
- R7: A `sw_req` presented while `busy` is high is ignored. The switch in progress completes unchanged, and `busy` falls after it.
- R8: The stored word at row r and column c of the active plane drives `cfg_out[(r*COLS+c)*32 +: 32]`.
- R9: A switch to the context that is already active reloads the holding register from that context's current stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_row | input | log2(ROWS) | Write row address |
| wr_col | input | log2(COLS) | Write column-word address |
| wr_ctx | input | log2(NUM_CTX) | Write destination context |
| wr_data | input | 32 | Write data word |
| rd_req | input | 1 | Readback request |
| rd_row | input | log2(ROWS) | Readback row address |
| rd_col | input | log2(COLS) | Readback column-word address |
| rd_ctx | input | log2(NUM_CTX) | Readback context |
| rd_data | output | 32 | Readback word, one cycle after request |
| rd_valid | output | 1 | Readback data valid |
| sw_req | input | 1 | Context switch request |
| sw_ctx | input | log2(NUM_CTX) | Context to activate |
| busy | output | 1 | Switch in progress; writes and switches are not accepted |
| active_ctx | output | log2(NUM_CTX) | Currently active context |
| cfg_out | output | ROWS*COLS*32 | Held bits of the active plane, driving the fabric |

## Verification
Several properties are checked on every cycle by assertions:
- `busy` lasts exactly two cycles per switch.
- The held bits and the active context index move only on the load step.
- `rd_valid` trails a request by one cycle.
- The holding register is clear just after reset.

Only the bench's scenarios can show that the data are correct. This covers:
- which word a write reached;
- that writes and switches arriving during a switch are dropped;
- that the loaded plane includes earlier writes to the active context;
- the bit placement of each word on `cfg_out`.

The bench's reference model of every plane and of the held copy compares readback and `cfg_out` on every cycle of a random mix of writes, reads and switches.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    // Width of one column word of configuration bits
    localparam int WORD_W = 32;

    // Steps of the context switch sequence
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DETACH = 2'd1,
        PH_LOAD   = 2'd2
    } sw_phase_e;

    // Bit offset of a word inside a flattened plane
    function automatic int unsigned word_lsb(int unsigned row, int unsigned col, int unsigned cols);
        return (row * cols + col) * WORD_W;
    endfunction

endpackage

// File: rtl/cfgmem_plane_store.sv
module cfgmem_plane_store
    import cfgmem_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int ROWS    = 8,
    parameter int COLS    = 4,
    localparam int CTX_W  = $clog2(NUM_CTX),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int WORDS  = ROWS * COLS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [COL_W-1:0]        wr_col,
    input  logic [CTX_W-1:0]        wr_ctx,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [ROW_W-1:0]        rd_row,
    input  logic [COL_W-1:0]        rd_col,
    input  logic [CTX_W-1:0]        rd_ctx,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    rd_valid,
    input  logic [CTX_W-1:0]        plane_sel,
    output logic [WORDS*WORD_W-1:0] plane_bits
);

    logic [NUM_CTX-1:0][WORDS-1:0][WORD_W-1:0] mem_flat;
    logic [NUM_CTX-1:0] ctx_hit;
    logic [ROWS-1:0]    row_hit;
    logic [COLS-1:0]    col_hit;

    // Three independent decoders; a word is written only where all agree (R2)
    always_comb begin
        ctx_hit = '0;
        row_hit = '0;
        col_hit = '0;
        ctx_hit[wr_ctx] = wr_en;
        row_hit[wr_row] = wr_en;
        col_hit[wr_col] = wr_en;
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar k = 0; k < COLS; k++) begin : g_col
                logic [WORD_W-1:0] word_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        word_q <= '0;
                    else if (ctx_hit[c] && row_hit[r] && col_hit[k])
                        word_q <= wr_data;
                end
                assign mem_flat[c][r*COLS+k] = word_q;
            end
        end
    end

    // Registered readback, read-before-write on a same-cycle collision (R4)
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= mem_flat[rd_ctx][{rd_row, rd_col}];
        end
    end

    assign plane_bits = mem_flat[plane_sel];

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid == $past(rd_en));

endmodule

// File: rtl/cfgmem_switch_ctrl.sv
module cfgmem_switch_ctrl
    import cfgmem_pkg::*;
#(
    parameter int NUM_CTX = 4,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_req,
    input  logic [CTX_W-1:0] sw_ctx,
    output logic             busy,
    output logic             load_en,
    output logic [CTX_W-1:0] load_ctx,
    output logic [CTX_W-1:0] active_ctx
);

    sw_phase_e        phase_q;
    logic [CTX_W-1:0] target_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            target_q   <= '0;
            active_ctx <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (sw_req) begin
                        phase_q  <= PH_DETACH;
                        target_q <= sw_ctx;
                    end
                end
                PH_DETACH: phase_q <= PH_LOAD;
                PH_LOAD: begin
                    phase_q    <= PH_IDLE;
                    active_ctx <= target_q;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase_q != PH_IDLE);
    assign load_en  = (phase_q == PH_LOAD);
    assign load_ctx = target_q;

    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    assert_busy_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    assert_active_moves_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_ctx) |-> $past(phase_q == PH_LOAD));

    assert_switch_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DETACH) |=> $stable(target_q));

endmodule

// File: rtl/cfgmem_hold_reg.sv
module cfgmem_hold_reg #(
    parameter int WIDTH = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] plane_bits,
    output logic [WIDTH-1:0] cfg_out
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_out <= '0;
        else if (load_en)
            cfg_out <= plane_bits;
    end

    assert_held_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(cfg_out));

    assert_cleared_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_out == '0));

endmodule

// File: rtl/cfg_context_mem.sv
module cfg_context_mem
    import cfgmem_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int ROWS    = 8,
    parameter int COLS    = 4,
    localparam int CTX_W  = $clog2(NUM_CTX),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int CFG_W  = ROWS * COLS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [CTX_W-1:0]  rd_ctx,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              sw_req,
    input  logic [CTX_W-1:0]  sw_ctx,
    output logic              busy,
    output logic [CTX_W-1:0]  active_ctx,
    output logic [CFG_W-1:0]  cfg_out
);

    logic             wr_en;
    logic             load_en;
    logic [CTX_W-1:0] load_ctx;
    logic [CFG_W-1:0] plane_bits;

    // Writes stall while a switch is in flight (R6)
    assign wr_en = wr_req && !busy;

    cfgmem_switch_ctrl #(.NUM_CTX(NUM_CTX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sw_req     (sw_req),
        .sw_ctx     (sw_ctx),
        .busy       (busy),
        .load_en    (load_en),
        .load_ctx   (load_ctx),
        .active_ctx (active_ctx)
    );

    cfgmem_plane_store #(.NUM_CTX(NUM_CTX), .ROWS(ROWS), .COLS(COLS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .wr_col     (wr_col),
        .wr_ctx     (wr_ctx),
        .wr_data    (wr_data),
        .rd_en      (rd_req),
        .rd_row     (rd_row),
        .rd_col     (rd_col),
        .rd_ctx     (rd_ctx),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .plane_sel  (load_ctx),
        .plane_bits (plane_bits)
    );

    cfgmem_hold_reg #(.WIDTH(CFG_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .plane_bits (plane_bits),
        .cfg_out    (cfg_out)
    );

    assert_active_stable_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sw_req) |=> $stable(active_ctx));

endmodule

// File: tb/cfg_context_mem_test.sv
module cfg_context_mem_test;

    localparam int NUM_CTX = 4;
    localparam int ROWS    = 8;
    localparam int COLS    = 4;
    localparam int WORDS   = ROWS * COLS;
    localparam int CTX_W   = $clog2(NUM_CTX);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS);
    localparam int CFG_W   = WORDS * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_req = 1'b0, rd_req = 1'b0, sw_req = 1'b0;
    logic [ROW_W-1:0] wr_row = '0, rd_row = '0;
    logic [COL_W-1:0] wr_col = '0, rd_col = '0;
    logic [CTX_W-1:0] wr_ctx = '0, rd_ctx = '0, sw_ctx = '0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             rd_valid, busy;
    logic [CTX_W-1:0] active_ctx;
    logic [CFG_W-1:0] cfg_out;

    always #5 clk = ~clk;

    cfg_context_mem #(.NUM_CTX(NUM_CTX), .ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_row(wr_row), .wr_col(wr_col), .wr_ctx(wr_ctx), .wr_data(wr_data),
        .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col), .rd_ctx(rd_ctx),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .sw_req(sw_req), .sw_ctx(sw_ctx), .busy(busy), .active_ctx(active_ctx),
        .cfg_out(cfg_out)
    );

    // Reference model
    logic [31:0]      m_mem [NUM_CTX][WORDS];
    logic [CFG_W-1:0] m_hold;
    int               m_act, m_tgt, m_ph;
    int               n_cmp = 0, n_bad = 0;
    bit               done = 0;

    function automatic logic [CFG_W-1:0] plane_of(int c);
        logic [CFG_W-1:0] v;
        for (int w = 0; w < WORDS; w++) v[w*32 +: 32] = m_mem[c][w];
        return v;
    endfunction

    task automatic chk(string tag, logic [CFG_W-1:0] act, logic [CFG_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive, advance model, check all outputs after the edge
    task automatic cyc(bit w, int wr, int wc, int wx, logic [31:0] wd,
                       bit r, int rr, int rc, int rx, bit s, int sx);
        logic [31:0] exp_rd;
        wr_req = w; wr_row = ROW_W'(wr); wr_col = COL_W'(wc); wr_ctx = CTX_W'(wx); wr_data = wd;
        rd_req = r; rd_row = ROW_W'(rr); rd_col = COL_W'(rc); rd_ctx = CTX_W'(rx);
        sw_req = s; sw_ctx = CTX_W'(sx);
        exp_rd = m_mem[rx][rr*COLS+rc];
        if (w && m_ph == 0) m_mem[wx][wr*COLS+wc] = wd;
        case (m_ph)
            2: begin m_hold = plane_of(m_tgt); m_act = m_tgt; m_ph = 0; end
            1: m_ph = 2;
            default: if (s) begin m_tgt = sx; m_ph = 1; end
        endcase
        @(posedge clk);
        #1;
        chk("R4 rd_valid", CFG_W'(rd_valid), CFG_W'(r));
        if (r) chk("R4 rd_data", CFG_W'(rd_data), CFG_W'(exp_rd));
        chk("R5 busy", CFG_W'(busy), CFG_W'(m_ph != 0));
        chk("R5 active_ctx", CFG_W'(active_ctx), CFG_W'(m_act));
        chk("R3 cfg_out", cfg_out, m_hold);
        wr_req = 0; rd_req = 0; sw_req = 0;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CTX; c++)
            for (int w = 0; w < WORDS; w++) m_mem[c][w] = '0;
        m_hold = '0; m_act = 0; m_tgt = 0; m_ph = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk("R1 cfg_out zero", cfg_out, '0);
        chk("R1 active_ctx", CFG_W'(active_ctx), '0);
        chk("R1 busy", CFG_W'(busy), '0);
        chk("R1 rd_valid", CFG_W'(rd_valid), '0);
        cyc(0, 0, 0, 0, 0, 1, 5, 2, 3, 0, 0);
        chk("R1 stored word zero", CFG_W'(rd_data), '0);

        // R2: write an inactive plane and read it back; neighbours untouched
        cyc(1, 2, 3, 1, 32'hA5A5_5A5A, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 2, 3, 1, 0, 0);
        chk("R2 written word", CFG_W'(rd_data), CFG_W'(32'hA5A5_5A5A));
        cyc(0, 0, 0, 0, 0, 1, 2, 2, 1, 0, 0);
        chk("R2 neighbour word", CFG_W'(rd_data), '0);
        cyc(0, 0, 0, 0, 0, 1, 2, 3, 2, 0, 0);
        chk("R2 other context", CFG_W'(rd_data), '0);

        // R3/R4: write active context; held bits stay, readback shows stored word
        cyc(1, 0, 0, 0, 32'h0000_1234, 0, 0, 0, 0, 0, 0);
        chk("R3 cfg_out after active write", cfg_out, '0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R4 active readback is stored", CFG_W'(rd_data), CFG_W'(32'h1234));
        // R4: same-cycle read and write return the old value
        cyc(1, 0, 0, 0, 32'h0000_5678, 1, 0, 0, 0, 0, 0);
        chk("R4 collision old value", CFG_W'(rd_data), CFG_W'(32'h1234));

        // R5/R6/R7: switch to plane 1, write and switch during busy
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R5 busy detach", CFG_W'(busy), CFG_W'(1));
        chk("R5 cfg held during detach", cfg_out, '0);
        cyc(1, 0, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0);
        chk("R5 busy load", CFG_W'(busy), CFG_W'(1));
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        chk("R5 active after load", CFG_W'(active_ctx), CFG_W'(1));
        chk("R8 word placement", CFG_W'(cfg_out[(2*COLS+3)*32 +: 32]), CFG_W'(32'hA5A5_5A5A));
        idle();
        chk("R7 switch during busy ignored", CFG_W'(busy), '0);
        chk("R7 active unchanged", CFG_W'(active_ctx), CFG_W'(1));
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
        chk("R6 write during busy dropped", CFG_W'(rd_data), '0);

        // R9: reactivating the active plane reloads fresh contents
        cyc(1, 1, 1, 1, 32'h0000_0077, 0, 0, 0, 0, 0, 0);
        chk("R3 active write not visible", CFG_W'(cfg_out[(1*COLS+1)*32 +: 32]), '0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        idle();
        idle();
        chk("R9 reload same context", CFG_W'(cfg_out[(1*COLS+1)*32 +: 32]), CFG_W'(32'h77));

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 2) == 0, $urandom % ROWS, $urandom % COLS, $urandom % NUM_CTX, $urandom,
                ($urandom % 2) == 0, $urandom % ROWS, $urandom % COLS, $urandom % NUM_CTX,
                ($urandom % 8) == 0, $urandom % NUM_CTX);
        end
        repeat (3) idle();

        done = 1;
        summary();
        $finish;
    end

endmodule